// File: doc/BRIEF.md
# Multicycle Left-Shift Instruction Executor

This block executes one instruction: a logical shift to the left of a 16-bit register, by one or two places. It sits next to a four-entry register file (R0 to R3). An instruction word arrives with a valid strobe. When the block is idle and the word falls in the shift-left opcode range, the block accepts it. It then runs for a fixed number of cycles that depends on the shift amount. At the end it writes the shifted value back to the register it read and updates a sign flag and a zero flag.

While an instruction runs, the block holds ready low and holds an interrupt-inhibit output high. It pulses done in the last cycle of the run. A valid word outside the opcode range is rejected with a one-cycle illegal pulse and changes nothing.

The register file has a debug port. The port reads any register at all times and loads any register while the block is idle, so that operands can be preset before a shift.

Top module: `shl_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears all four registers, both flags and the busy state, so that after reset ready is 1, and busy, done, illegal and inhibit are 0.
- R2: A word with valid high while ready is high is accepted when (word & 0xFFF8) == 0x0048. Bit 2 selects the shift amount (0 = one place, 1 = two places). Bits 1:0 select the register (00 = R0, 01 = R1, 10 = R2, 11 = R3).
- R3: The result is the selected register shifted left by the chosen amount. The bits leaving the top are dropped, the vacated low bits become zero, and the result goes back to the same register. No other register changes.
- R4: The sign flag takes bit 15 of the result. The zero flag is 1 exactly when the result is all zeros. Both flags are visible after the edge that ends the done cycle, and they change at no other time.
- R5: The run lasts 6 cycles for a one-place shift and 8 cycles for a two-place shift, counting the acceptance cycle. After the accepting edge, busy is high for 5 or 7 cycles. Done is high only in the last of those cycles.
- R6: While busy is high, ready is low and the interrupt-inhibit output is high. Any instruction word presented then is ignored: it is not accepted and raises no illegal pulse.
- R7: A valid word outside 0x0048 to 0x004F, presented while ready, raises illegal for the one cycle after the sampling edge. It leaves registers, flags and busy unchanged.
- R8: The debug port returns the register chosen by its select at all times. A debug write loads the chosen register at the next edge while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word strobe |
| instr_word | input | 16 | Instruction word |
| instr_ready | output | 1 | Block idle, can take a word |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of the run |
| illegal_op | output | 1 | One-cycle pulse for a rejected word |
| irq_inhibit | output | 1 | Interrupts must be held off |
| sign_flag | output | 1 | Bit 15 of the last result |
| zero_flag | output | 1 | Last result was zero |
| dbg_sel | input | 2 | Debug register select |
| dbg_we | input | 1 | Debug write enable |
| dbg_wdata | input | 16 | Debug write data |
| dbg_rdata | output | 16 | Debug read data |

## Verification
The assertions assume the operand register does not change during a run. This holds because debug writes are dropped while busy, and the bench issues its preloads only between runs. The latency check also assumes that the word sampled at acceptance is the one being executed. The stimulus therefore draws random words, about two thirds of them forced into the opcode range, holds each word only for its sampling edge, and drives an intruding legal word during some runs to exercise the ignore path.

// File: rtl/shl_pkg.sv
package shl_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam logic [15:0] OPC_MASK = 16'hFFF8;
  localparam logic [15:0] OPC_BASE = 16'h0048;

  function automatic logic opcode_hit(input logic [WORD_W-1:0] w);
    return (w & OPC_MASK) == OPC_BASE;
  endfunction

  function automatic logic [WORD_W-1:0] shift_apply(input logic [WORD_W-1:0] v,
                                                    input logic two);
    return two ? (v << 2) : (v << 1);
  endfunction

  function automatic logic is_zero(input logic [WORD_W-1:0] v);
    return v == '0;
  endfunction
endpackage

// File: rtl/shl_decode.sv
module shl_decode
  import shl_pkg::*;
#(
  parameter int unsigned SEL_W = 2
) (
  input  logic [WORD_W-1:0] word,
  output logic              hit,
  output logic              two,
  output logic [SEL_W-1:0]  sel
);
  always_comb begin
    hit = opcode_hit(word);
    two = word[2];
    sel = word[SEL_W-1:0];
  end
endmodule

// File: rtl/shl_sequencer.sv
module shl_sequencer #(
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned CYC_ONE = 6,
  parameter int unsigned CYC_TWO = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_two,
  input  logic [SEL_W-1:0] start_sel,
  output logic             busy,
  output logic             last,
  output logic             two,
  output logic [SEL_W-1:0] sel
);
  localparam int unsigned CNT_W = $clog2(CYC_TWO + 1);
  localparam logic [CNT_W-1:0] END_ONE = CNT_W'(CYC_ONE - 2);
  localparam logic [CNT_W-1:0] END_TWO = CNT_W'(CYC_TWO - 2);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             two_q;
  logic [SEL_W-1:0] sel_q;
  logic             at_end;

  assign at_end = cnt_q == (two_q ? END_TWO : END_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      two_q  <= 1'b0;
      sel_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      two_q  <= start_two;
      sel_q  <= start_sel;
    end else if (busy_q) begin
      if (at_end) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy = busy_q;
  assign last = busy_q && at_end;
  assign two  = two_q;
  assign sel  = sel_q;
endmodule

// File: rtl/shl_regfile.sv
module shl_regfile #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREGS  = 4,
  localparam int unsigned SEL_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  wsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  rsel,
  output logic [DATA_W-1:0] rdata,
  input  logic [SEL_W-1:0]  dsel,
  output logic [DATA_W-1:0] ddata
);
  logic [DATA_W-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                           regs_q[g] <= '0;
      else if (we && wsel == SEL_W'(g))  regs_q[g] <= wdata;
    end
  end

  assign rdata = regs_q[rsel];
  assign ddata = regs_q[dsel];
endmodule

// File: rtl/shl_exec_unit.sv
module shl_exec_unit
  import shl_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned NREGS   = 4,
  parameter int unsigned CYC_ONE = 6,
  parameter int unsigned CYC_TWO = 8,
  localparam int unsigned SEL_W  = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [15:0]       instr_word,
  output logic              instr_ready,
  output logic              busy,
  output logic              done,
  output logic              illegal_op,
  output logic              irq_inhibit,
  output logic              sign_flag,
  output logic              zero_flag,
  input  logic [SEL_W-1:0]  dbg_sel,
  input  logic              dbg_we,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata
);
  logic              dec_hit, dec_two;
  logic [SEL_W-1:0]  dec_sel;
  logic              accept_ev, reject_ev;
  logic              run_busy, run_last, run_two;
  logic [SEL_W-1:0]  run_sel;
  logic [DATA_W-1:0] op_data, commit_data;
  logic              rf_we;
  logic [SEL_W-1:0]  rf_wsel;
  logic [DATA_W-1:0] rf_wdata;
  logic              ill_q, sign_q, zero_q;

  shl_decode #(.SEL_W(SEL_W)) u_dec (
    .word(instr_word), .hit(dec_hit), .two(dec_two), .sel(dec_sel)
  );

  assign accept_ev = instr_valid && !run_busy && dec_hit;
  assign reject_ev = instr_valid && !run_busy && !dec_hit;

  shl_sequencer #(.SEL_W(SEL_W), .CYC_ONE(CYC_ONE), .CYC_TWO(CYC_TWO)) u_seq (
    .clk(clk), .rst(rst), .start(accept_ev), .start_two(dec_two),
    .start_sel(dec_sel), .busy(run_busy), .last(run_last),
    .two(run_two), .sel(run_sel)
  );

  assign commit_data = DATA_W'(shift_apply(WORD_W'(op_data), run_two));

  always_comb begin
    rf_we    = 1'b0;
    rf_wsel  = dbg_sel;
    rf_wdata = dbg_wdata;
    if (run_last) begin
      rf_we    = 1'b1;
      rf_wsel  = run_sel;
      rf_wdata = commit_data;
    end else if (dbg_we && !run_busy) begin
      rf_we    = 1'b1;
    end
  end

  shl_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .wsel(rf_wsel), .wdata(rf_wdata),
    .rsel(run_sel), .rdata(op_data), .dsel(dbg_sel), .ddata(dbg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ill_q  <= 1'b0;
      sign_q <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      ill_q <= reject_ev;
      if (run_last) begin
        sign_q <= commit_data[DATA_W-1];
        zero_q <= is_zero(WORD_W'(commit_data));
      end
    end
  end

  assign instr_ready = !run_busy;
  assign busy        = run_busy;
  assign irq_inhibit = run_busy;
  assign done        = run_last;
  assign illegal_op  = ill_q;
  assign sign_flag   = sign_q;
  assign zero_flag   = zero_q;
endmodule

// File: rtl/shl_exec_chk.sv
module shl_exec_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CYC_ONE = 6,
  parameter int unsigned CYC_TWO = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_valid,
  input logic              instr_ready,
  input logic [15:0]       instr_word,
  input logic              busy,
  input logic              done,
  input logic              illegal_op,
  input logic              irq_inhibit,
  input logic              sign_flag,
  input logic              zero_flag,
  input logic [DATA_W-1:0] commit_data
);
  logic [7:0] span_q;
  logic [7:0] want_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      span_q <= '0;
      want_q <= 8'(CYC_ONE);
    end else if (instr_valid && instr_ready && (instr_word & 16'hFFF8) == 16'h0048) begin
      span_q <= '0;
      want_q <= instr_word[2] ? 8'(CYC_TWO) : 8'(CYC_ONE);
    end else if (busy) begin
      span_q <= span_q + 1'b1;
    end
  end

  // R5
  busy_span_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy && span_q == want_q - 8'd2));

  // R5
  done_ends_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy && !done);

  // R6
  inhibit_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (irq_inhibit && !instr_ready));

  // R2
  start_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(instr_valid && instr_ready));

  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(done)) |-> ($stable(sign_flag) && $stable(zero_flag)));

  // R4
  flag_value_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(done)) |->
      (sign_flag == $past(commit_data[DATA_W-1]) && zero_flag == ($past(commit_data) == '0)));

  // R7
  illegal_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && illegal_op) |-> ($past(instr_valid && instr_ready) && !busy));
endmodule

bind shl_exec_unit shl_exec_chk #(.DATA_W(DATA_W), .CYC_ONE(CYC_ONE), .CYC_TWO(CYC_TWO)) u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
  .instr_word(instr_word), .busy(busy), .done(done), .illegal_op(illegal_op),
  .irq_inhibit(irq_inhibit), .sign_flag(sign_flag), .zero_flag(zero_flag),
  .commit_data(commit_data)
);

// File: tb/sim_shl_exec_unit.sv
`timescale 1ns/1ps
module sim_shl_exec_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic [15:0] instr_word;
  logic        instr_ready, busy, done, illegal_op, irq_inhibit, sign_flag, zero_flag;
  logic [1:0]  dbg_sel;
  logic        dbg_we;
  logic [15:0] dbg_wdata, dbg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] mdl [4];
  logic        m_sign, m_zero;

  always #5 clk = ~clk;

  shl_exec_unit u0 (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .instr_ready(instr_ready), .busy(busy), .done(done), .illegal_op(illegal_op),
    .irq_inhibit(irq_inhibit), .sign_flag(sign_flag), .zero_flag(zero_flag),
    .dbg_sel(dbg_sel), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
  );

  function automatic logic legal(input logic [15:0] w);
    return w[15:3] == 13'b0000_0000_0100_1;
  endfunction

  function automatic logic [15:0] expect_shift(input logic [15:0] v, input int places);
    logic [15:0] r = v;
    for (int i = 0; i < places; i++) r = {r[14:0], 1'b0};
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int r = 0; r < 4; r++) begin
      dbg_sel = 2'(r);
      #1;
      check(dbg_rdata === mdl[r], req, 32'(dbg_rdata), 32'(mdl[r]));
    end
    check(sign_flag === m_sign, req, 32'(sign_flag), 32'(m_sign));
    check(zero_flag === m_zero, req, 32'(zero_flag), 32'(m_zero));
  endtask

  task automatic preload(input int r, input logic [15:0] v);
    @(negedge clk);
    dbg_sel = 2'(r); dbg_we = 1'b1; dbg_wdata = v;
    @(negedge clk);
    dbg_we = 1'b0;
    mdl[r] = v;
  endtask

  task automatic run_shift(input logic [15:0] w, input logic intrude);
    int places = w[2] ? 2 : 1;
    int len    = w[2] ? 8 : 6;
    int rr     = int'(w[1:0]);
    @(negedge clk);
    instr_valid = 1'b1; instr_word = w;
    @(negedge clk);
    if (intrude) instr_word = {13'b0000_0000_0100_1, 1'b1, ~w[1:0]};
    else         instr_valid = 1'b0;
    for (int k = 0; k < len - 1; k++) begin
      check(busy === 1'b1 && instr_ready === 1'b0 && irq_inhibit === 1'b1, "R6 busy/ready/inhibit",
            {busy, instr_ready, irq_inhibit}, 3'b101);
      check(done === (k == len - 2), "R5 done timing", 32'(done), 32'(k == len - 2));
      check(illegal_op === 1'b0, "R6 no illegal while busy", 32'(illegal_op), 0);
      if (k == 2) instr_valid = 1'b0;
      @(negedge clk);
    end
    check(busy === 1'b0 && done === 1'b0, "R5 run length", {busy, done}, 0);
    mdl[rr] = expect_shift(mdl[rr], places);
    m_sign  = mdl[rr][15];
    m_zero  = (mdl[rr] == 16'h0);
    check_regs(intrude ? "R6 ignored word / R3 R4" : "R3 R4 result and flags");
  endtask

  task automatic run_illegal(input logic [15:0] w);
    @(negedge clk);
    instr_valid = 1'b1; instr_word = w;
    @(negedge clk);
    instr_valid = 1'b0;
    check(illegal_op === 1'b1 && busy === 1'b0, "R7 illegal pulse", {illegal_op, busy}, 2'b10);
    @(negedge clk);
    check(illegal_op === 1'b0, "R7 pulse one cycle", 32'(illegal_op), 0);
    check_regs("R7 state unchanged");
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd20231));
    rst = 1'b1; instr_valid = 1'b0; instr_word = '0;
    dbg_sel = '0; dbg_we = 1'b0; dbg_wdata = '0;
    for (int r = 0; r < 4; r++) mdl[r] = '0;
    m_sign = 1'b0; m_zero = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(instr_ready === 1'b1 && busy === 1'b0 && done === 1'b0 && illegal_op === 1'b0 &&
          irq_inhibit === 1'b0, "R1 reset outputs",
          {instr_ready, busy, done, illegal_op, irq_inhibit}, 5'b10000);
    check_regs("R1 reset registers");

    // R8 debug load and read
    preload(0, 16'h8001); preload(1, 16'hC000); preload(2, 16'h4000); preload(3, 16'h3FFF);
    check_regs("R8 debug load");

    // R2 R3 R4 directed corners
    run_shift(16'h0048, 1'b0);  // R0 one place: 0x0002
    run_shift(16'h004D, 1'b0);  // R1 two places: zero
    run_shift(16'h004A, 1'b0);  // R2 one place: sign
    run_shift(16'h004F, 1'b0);  // R3 two places: 0xFFFC
    run_shift(16'h004C, 1'b1);  // R0 with intruding word

    // R8 debug write dropped while busy
    @(negedge clk);
    instr_valid = 1'b1; instr_word = 16'h0049;
    @(negedge clk);
    instr_valid = 1'b0; dbg_sel = 2'd2; dbg_we = 1'b1; dbg_wdata = 16'h1234;
    @(negedge clk);
    dbg_we = 1'b0;
    repeat (5) @(negedge clk);
    mdl[1] = expect_shift(mdl[1], 1); m_sign = mdl[1][15]; m_zero = (mdl[1] == 0);
    check_regs("R8 debug write ignored while busy");

    // R7 illegal words at range edges
    run_illegal(16'h0047);
    run_illegal(16'h0050);
    run_illegal(16'h1048);
    run_illegal(16'h0040);

    // random mix
    for (int i = 0; i < 150; i++) begin
      if ($urandom_range(0, 3) == 0) preload(int'($urandom_range(0, 3)), 16'($urandom));
      if ($urandom_range(0, 2) != 0) w = 16'h0048 | 16'($urandom_range(0, 7));
      else                           w = 16'($urandom);
      if (legal(w)) run_shift(w, 1'($urandom_range(0, 1)));
      else          run_illegal(w);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule